// File: doc/BRIEF.md
# Pager call record formatter

This block turns decoded pager call events into byte records for a message RAM. A call arrives as a sequence of events on one valid/ready stream: a start event carrying the function bits and the sync source, zero or more message code-word events carrying a 20-bit payload and an uncorrectable flag, and an end event. For each stored call the block writes a 3-byte header, then 3 bytes per message code-word, then a 3-byte terminator. It writes one byte per cycle through a plain write port whose address counts up from zero after reset.

The stream has back-pressure. An event is taken on a clock edge where `ev_valid` and `ev_ready` are both high. `ev_ready` is low while a record's three bytes are being written, and it rises in the cycle after the last byte. The source must hold the event fields stable while `ev_valid` is high and `ev_ready` is low. Events that do not fit the call sequence are taken and have no effect: a word or an end with no open call, or a start while a call is open.

The RAM holds `DEPTH` bytes, and reset empties it. Every stored call has 3 bytes set aside for its terminator. A code-word that would eat into that space is dropped, and the terminator records the loss. A call that begins without room for both a header and a terminator is discarded whole.

Top module: `pager_rec_fmt`

## Requirements
- R1: After reset the block writes nothing, `wr_addr` is 0, `ev_ready` is 1, and `ram_full` and `call_done` are 0.
- R2: A start event with no call open writes a header. Byte 0 is {1, 0, DF, sync id[2:0], func[1:0]} (MSB first), and bytes 1 and 2 are 0. A sync id of 7 means the standard sync word, and other values give the user sync-word number.
- R3: The header DF bit is 1 exactly when `ev_sync_ok` was 0 on the start event, meaning the batch's sync word matched neither the standard nor any user word.
- R4: A word event inside a stored call writes {4'b0, payload[19:16]}, payload[15:8], payload[7:0], in that order.
- R5: An end event inside a stored call writes a terminator. Byte 0 is {1, 1, DF, OVF, 4'b0}, and bytes 1 and 2 are 0. DF is 1 when any word event since the last word with `ev_new_batch`=1 (or since the start) had `ev_uncorr`=1. A word with `ev_new_batch`=1 begins a new batch.
- R6: A call with no word events writes exactly 6 bytes: its header and its terminator.
- R7: A word is stored only if at least 6 bytes are free before it. Otherwise it writes nothing and the terminator's OVF bit is set. No write ever has an address of `DEPTH` or more.
- R8: `ram_full` is 1 exactly when fewer than 6 bytes are free. A start event taken while it is 1 discards the whole call: the call writes no bytes and raises no done pulse.
- R9: `call_done` is high for one cycle, the cycle right after the terminator's last byte is written.
- R10: Each record's bytes are written in 3 back-to-back cycles at consecutive addresses, starting the cycle after the event is taken. `ev_ready` is low during these cycles. Word or end events with no call open write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset; empties the RAM |
| ev_valid | input | 1 | event present |
| ev_ready | output | 1 | event taken on this edge if valid |
| ev_kind | input | 2 | 0 start, 1 word, 2 end, 3 no-op |
| ev_func | input | 2 | function bits (start) |
| ev_sync_id | input | 3 | sync source number, 7 = standard (start) |
| ev_sync_ok | input | 1 | batch sync word matched (start) |
| ev_payload | input | 20 | message payload bits (word) |
| ev_uncorr | input | 1 | code-word uncorrectable (word) |
| ev_new_batch | input | 1 | first word of a new batch (word) |
| wr_en | output | 1 | RAM byte write strobe |
| wr_addr | output | $clog2(DEPTH) | RAM byte address |
| wr_data | output | 8 | RAM byte |
| ram_full | output | 1 | fewer than 6 bytes free |
| call_done | output | 1 | one-cycle pulse after a terminator is written |

## Verification
Some internal faults show at once: a byte counter or shift register out of step puts bytes at the wrong address or in the wrong order within three cycles of the event that caused it. A stale batch-error or overflow flag stays hidden until that call's terminator is written, which can be many events later. A fault in the free-space test shows only near the top of the RAM, as a missing or extra data record or a call that should have been discarded. The bench therefore fills the RAM again and again, and it compares every byte and every done pulse after each call ends.

// File: rtl/pager_rec_pkg.sv
package pager_rec_pkg;
  typedef enum logic [1:0] {
    EV_START = 2'd0,
    EV_WORD  = 2'd1,
    EV_END   = 2'd2,
    EV_NOP   = 2'd3
  } ev_kind_e;

  typedef enum logic [1:0] {
    REC_HDR  = 2'd0,
    REC_DATA = 2'd1,
    REC_TERM = 2'd2
  } rec_sel_e;

  localparam int REC_BYTES = 3;
  localparam int REC_W     = 8 * REC_BYTES;
  localparam int PAYLOAD_W = 20;
  localparam int RESERVE   = 2 * REC_BYTES;
endpackage

// File: rtl/pager_rec_pack.sv
module pager_rec_pack
  import pager_rec_pkg::*;
(
  input  rec_sel_e               sel,
  input  logic [1:0]             func,
  input  logic [2:0]             sync_id,
  input  logic                   sync_ok,
  input  logic [PAYLOAD_W-1:0]   payload,
  input  logic                   term_df,
  input  logic                   term_ovf,
  output logic [REC_W-1:0]       rec
);
  localparam int PAD_W = REC_W - PAYLOAD_W;

  always_comb begin
    case (sel)
      REC_HDR:  rec = {2'b10, ~sync_ok, sync_id, func, {(REC_W-8){1'b0}}};
      REC_DATA: rec = {{PAD_W{1'b0}}, payload};
      REC_TERM: rec = {2'b11, term_df, term_ovf, 4'b0000, {(REC_W-8){1'b0}}};
      default:  rec = '0;
    endcase
  end
endmodule

// File: rtl/pager_rec_ctl.sv
module pager_rec_ctl
  import pager_rec_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     accept,
  input  ev_kind_e kind,
  input  logic     uncorr,
  input  logic     new_batch,
  input  logic     room_ok,
  output logic     load,
  output rec_sel_e sel,
  output logic     term_is,
  output logic     term_df,
  output logic     term_ovf
);
  logic in_call, drop, batch_df, ovf;

  always_comb begin
    load = 1'b0;
    sel  = REC_HDR;
    if (accept) begin
      case (kind)
        EV_START: begin load = !in_call && room_ok;         sel = REC_HDR;  end
        EV_WORD:  begin load = in_call && !drop && room_ok; sel = REC_DATA; end
        EV_END:   begin load = in_call && !drop;            sel = REC_TERM; end
        default:  begin load = 1'b0;                        sel = REC_HDR;  end
      endcase
    end
  end

  assign term_is  = (sel == REC_TERM);
  assign term_df  = batch_df;
  assign term_ovf = ovf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_call  <= 1'b0;
      drop     <= 1'b0;
      batch_df <= 1'b0;
      ovf      <= 1'b0;
    end else if (accept) begin
      case (kind)
        EV_START: if (!in_call) begin
          in_call  <= 1'b1;
          drop     <= !room_ok;
          batch_df <= 1'b0;
          ovf      <= 1'b0;
        end
        EV_WORD: if (in_call) begin
          batch_df <= (batch_df && !new_batch) || uncorr;
          if (!room_ok) ovf <= 1'b1;
        end
        EV_END: if (in_call) in_call <= 1'b0;
        default: ;
      endcase
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_call && ovf && !(accept && kind == EV_START)) |=> ovf); // R7
  AST_LOAD_ONE_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    (load && sel == REC_HDR) |=> in_call); // R2
endmodule

// File: rtl/pager_rec_emit.sv
module pager_rec_emit
  import pager_rec_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_term,
  input  logic [REC_W-1:0] rec,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [7:0]       wr_data,
  output logic             idle,
  output logic             room_ok,
  output logic             done
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int LW = $clog2(REC_BYTES + 1);
  localparam logic [CW-1:0] ROOM_LIMIT = CW'(DEPTH - RESERVE);

  logic [REC_W-1:0] sr;
  logic [LW-1:0]    left;
  logic [CW-1:0]    addr;
  logic             term_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr     <= '0;
      left   <= '0;
      addr   <= '0;
      term_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        sr     <= rec;
        left   <= LW'(REC_BYTES);
        term_q <= load_term;
      end else if (left != '0) begin
        sr   <= sr << 8;
        left <= left - LW'(1);
        addr <= addr + CW'(1);
        if (left == LW'(1) && term_q) done <= 1'b1;
      end
    end
  end

  assign wr_en   = (left != '0);
  assign wr_data = sr[REC_W-1 -: 8];
  assign wr_addr = addr[AW-1:0];
  assign idle    = (left == '0);
  assign room_ok = (addr <= ROOM_LIMIT);

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(addr) < DEPTH)); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (addr == $past(addr) + CW'(1))); // R10
  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !wr_en); // R10
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_en) && !wr_en)); // R9
endmodule

// File: rtl/pager_rec_fmt.sv
module pager_rec_fmt
  import pager_rec_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_valid,
  output logic                 ev_ready,
  input  logic [1:0]           ev_kind,
  input  logic [1:0]           ev_func,
  input  logic [2:0]           ev_sync_id,
  input  logic                 ev_sync_ok,
  input  logic [PAYLOAD_W-1:0] ev_payload,
  input  logic                 ev_uncorr,
  input  logic                 ev_new_batch,
  output logic                 wr_en,
  output logic [AW-1:0]        wr_addr,
  output logic [7:0]           wr_data,
  output logic                 ram_full,
  output logic                 call_done
);
  logic             accept, load, term_is, term_df, term_ovf, idle, room_ok;
  rec_sel_e         sel;
  logic [REC_W-1:0] rec;
  ev_kind_e         kind;

  assign kind     = ev_kind_e'(ev_kind);
  assign ev_ready = idle;
  assign accept   = ev_valid && idle;
  assign ram_full = !room_ok;

  pager_rec_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .kind(kind),
    .uncorr(ev_uncorr), .new_batch(ev_new_batch), .room_ok(room_ok),
    .load(load), .sel(sel), .term_is(term_is),
    .term_df(term_df), .term_ovf(term_ovf)
  );

  pager_rec_pack u_pack (
    .sel(sel), .func(ev_func), .sync_id(ev_sync_id), .sync_ok(ev_sync_ok),
    .payload(ev_payload), .term_df(term_df), .term_ovf(term_ovf), .rec(rec)
  );

  pager_rec_emit #(.DEPTH(DEPTH)) u_emit (
    .clk(clk), .rst_n(rst_n), .load(load), .load_term(term_is), .rec(rec),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .idle(idle), .room_ok(room_ok), .done(call_done)
  );

  AST_FULL_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_full && accept && kind != EV_END) |=> !wr_en); // R8
  AST_STORE_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (wr_en && !ev_ready)); // R10
endmodule

// File: tb/test_pager_rec_fmt.sv
module test_pager_rec_fmt;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, ev_ready;
  logic [1:0] ev_kind = 2'd3, ev_func = 2'd0;
  logic [2:0] ev_sync_id = 3'd0;
  logic ev_sync_ok = 1'b1, ev_uncorr = 1'b0, ev_new_batch = 1'b0;
  logic [19:0] ev_payload = '0;
  logic wr_en, ram_full, call_done;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;

  always #5 clk = ~clk;

  pager_rec_fmt #(.DEPTH(DEPTH)) i_pager_rec_fmt (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_func(ev_func), .ev_sync_id(ev_sync_id),
    .ev_sync_ok(ev_sync_ok), .ev_payload(ev_payload), .ev_uncorr(ev_uncorr),
    .ev_new_batch(ev_new_batch), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ram_full(ram_full), .call_done(call_done)
  );

  int vecs = 0, bad = 0, cyc = 0;
  logic [7:0] cap [DEPTH];
  logic [7:0] expm [DEPTH];
  int nwr = 0, ndone = 0, eaddr = 0, edone = 0, chk_from = 0;
  bit m_in = 0, m_drop = 0, m_ovf = 0, m_bdf = 0, prev_wr = 0;

  task automatic check(bit ok, string req, int act, int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (call_done) begin
        ndone++;
        check(prev_wr && nwr == eaddr, "R9 done timing", nwr, eaddr);
      end
      if (wr_en) begin
        if (int'(wr_addr) < DEPTH) cap[wr_addr] = wr_data;
        nwr++;
      end
      prev_wr = wr_en;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  function automatic logic [7:0] hdr_b(bit df, logic [2:0] s, logic [1:0] f);
    return {2'b10, df, s, f};
  endfunction
  function automatic logic [7:0] term_b(bit df, bit ovf);
    return {2'b11, df, ovf, 4'b0000};
  endfunction

  task automatic push(logic [7:0] b);
    expm[eaddr] = b;
    eaddr++;
  endtask

  task automatic send(logic [1:0] k);
    ev_kind = k;
    ev_valid = 1'b1;
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ev_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nwr = 0; ndone = 0; eaddr = 0; edone = 0; chk_from = 0;
    m_in = 0; m_drop = 0; prev_wr = 0;
    @(negedge clk);
    check(!wr_en && ev_ready && !ram_full && !call_done && wr_addr == '0,
          "R1 reset state", {wr_en, ev_ready, ram_full, call_done}, 4'b0100);
  endtask

  task automatic ev_start(logic [1:0] f, logic [2:0] s, bit ok);
    ev_func = f; ev_sync_id = s; ev_sync_ok = ok;
    send(2'd0);
    if (!m_in) begin
      m_in = 1; m_drop = (DEPTH - eaddr < 6); m_ovf = 0; m_bdf = 0;
      if (!m_drop) begin push(hdr_b(!ok, s, f)); push(8'h00); push(8'h00); end
    end
  endtask

  task automatic ev_word(logic [19:0] p, bit err, bit nb);
    ev_payload = p; ev_uncorr = err; ev_new_batch = nb;
    send(2'd1);
    if (m_in) begin
      m_bdf = (m_bdf && !nb) || err;
      if (DEPTH - eaddr >= 6) begin
        if (!m_drop) begin push({4'b0, p[19:16]}); push(p[15:8]); push(p[7:0]); end
      end else m_ovf = 1;
    end
  endtask

  task automatic ev_end();
    send(2'd2);
    if (m_in) begin
      m_in = 0;
      if (!m_drop) begin
        push(term_b(m_bdf, m_ovf)); push(8'h00); push(8'h00);
        edone++;
      end
    end
  endtask

  task automatic settle(string req);
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    check(nwr == eaddr, req, nwr, eaddr);
    for (int a = chk_from; a < eaddr; a++) check(cap[a] == expm[a], req, cap[a], expm[a]);
    check(ndone == edone, "R9 done count", ndone, edone);
    check(ram_full == (DEPTH - eaddr < 6), "R8 full flag", ram_full, DEPTH - eaddr < 6);
    chk_from = eaddr;
  endtask

  initial begin
    void'($urandom(32'd5003));
    do_reset();
    // R6: alert-only call
    ev_start(2'b10, 3'd7, 1'b1); ev_end(); settle("R6 alert-only");
    check(cap[0] == 8'h9E, "R2 header byte", cap[0], 8'h9E);
    check(cap[3] == 8'hC0, "R5 terminator byte", cap[3], 8'hC0);
    // R3: sync mismatch, R4 packing, R5 data-fail
    ev_start(2'b01, 3'd3, 1'b0); ev_word(20'hABCDE, 1'b1, 1'b0); ev_end(); settle("R4 packing");
    check(cap[6] == 8'hAD, "R3 header DF", cap[6], 8'hAD);
    check({cap[9], cap[10], cap[11]} == 24'h0ABCDE, "R4 data bytes", {cap[9], cap[10], cap[11]}, 24'h0ABCDE);
    check(cap[12] == 8'hE0, "R5 terminator DF", cap[12], 8'hE0);
    // R5: new batch clears data-fail
    ev_start(2'b00, 3'd1, 1'b1); ev_word(20'h12345, 1'b1, 1'b0);
    ev_word(20'h00F0F, 1'b0, 1'b1); ev_end(); settle("R5 batch clear");
    check(cap[eaddr-3] == 8'hC0, "R5 batch clear term", cap[eaddr-3], 8'hC0);
    // R10: stray events write nothing
    ev_word(20'hFFFFF, 1'b1, 1'b0); ev_end(); settle("R10 stray events");
    // R7: overflow inside a call
    ev_start(2'b11, 3'd0, 1'b1);
    for (int i = 0; i < 16; i++) ev_word(20'(i * 4099), 1'b0, 1'b0);
    ev_end(); settle("R7 overflow");
    check(cap[eaddr-3][4] == 1'b1, "R7 overflow bit", cap[eaddr-3], 8'hD0);
    // R8: call dropped when full
    ev_start(2'b00, 3'd2, 1'b1); ev_word(20'h11111, 1'b0, 1'b0); ev_end(); settle("R8 dropped call");

    for (int r = 0; r < 20; r++) begin
      do_reset();
      for (int c = 0; c < 12; c++) begin
        if ($urandom % 5 == 0) begin ev_word(20'($urandom), 1'b0, 1'b0); settle("R10 stray"); end
        ev_start(2'($urandom), 3'($urandom), ($urandom % 4) != 0);
        for (int w = 0; w < int'($urandom % 6); w++)
          ev_word(20'($urandom), ($urandom % 5) == 0, ($urandom % 3) == 0);
        ev_end();
        settle("R2 R4 R5 R7 random call");
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule